// File: doc/BRIEF.md
# I2C Bus Event Monitor

A passive observer for a two-wire I2C bus. The clock and data lines are sampled by the much faster system clock, cleaned up, and decoded into a stream of protocol events, in the way a logic-analyzer decoder would present them. The block never drives either line. It is meant to sit beside a bus and feed a trace buffer or a debug channel with one tagged record per event.

Each record has a valid strobe, a 3-bit kind code, an 8-bit data field, an acknowledge flag and a read/write flag. Line conditions (start, repeated start, stop, framing error) carry no data. Byte records are issued once the ninth clock of a byte has ended, so the acknowledge bit travels with the byte it belongs to. Clock stretching only lengthens the low phase and needs no special treatment. Ten-bit addressing is shown as two address records.

Event kind codes: 0 start, 1 repeated start, 2 stop, 3 seven-bit address, 4 ten-bit address upper byte, 5 ten-bit address lower byte, 6 data byte, 7 framing error.

Top module: `i2c_event_monitor`

## Requirements
- R1: While rst_ni is low and afterwards until bus activity, evt_valid_o stays low; the bus is taken as idle after reset.
- R2: A fall of SDA while SCL is high, with the bus idle, gives one record of kind 0 and the bus becomes busy.
- R3: A rise of SDA while SCL is high, with the bus busy, gives one record of kind 2 and the bus becomes idle; the same condition with the bus idle gives no record.
- R4: A fall of SDA while SCL is high, with the bus busy, gives one record of kind 1, and the next byte is decoded from its first bit as the first byte after a start.
- R5: Bits are taken most significant first, each as the SDA level during a high SCL phase; after the ninth high phase one byte record is issued with evt_data_o the eight bits and evt_ack_o = 1 when SDA was low on the ninth bit (ACK), 0 when high (NACK).
- R6: The first byte after a start or repeated start is reported as kind 3 with evt_rw_o equal to its bit 0 (1 read, 0 write), unless R7 applies.
- R7: A first byte whose bits 7..3 are 11110 is reported as kind 4 (evt_rw_o = bit 0); if that bit 0 is 0, the following byte is reported as kind 5.
- R8: Every further byte before the next start or stop is reported as kind 6, with no limit on their number.
- R9: A start or stop that arrives after at least one bit of a byte was taken discards that partial byte, gives a kind 7 record, and gives the record of the condition itself in the next cycle.
- R10: A level on SDA or SCL that lasts fewer than FILT_LEN system clock cycles has no effect on decoding; a level lasting longer is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, much faster than SCL |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as observed |
| sda_i | input | 1 | Bus data line as observed |
| evt_valid_o | output | 1 | One-cycle strobe: a record is present |
| evt_kind_o | output | 3 | Record kind code (see list above) |
| evt_data_o | output | 8 | Byte value for byte records, else 0 |
| evt_ack_o | output | 1 | 1 = byte was acknowledged, byte records only |
| evt_rw_o | output | 1 | Read flag of an address record (kinds 3, 4) |

## Verification
A wrong bit count or busy flag shows at the ports within one byte time: bytes come out shifted, a start is tagged as repeated, or a clean stop turns into a framing error. A stale ten-bit tracking flag mislabels the very next byte after the upper address byte. A glitch filter that is too short lets a two-cycle SDA pulse through as a start record at once, so each scenario compares the whole record sequence, kind, data and flags, against a sequence derived from the requirements.

// File: rtl/i2c_mon_pkg.sv
package i2c_mon_pkg;
  localparam int unsigned BYTE_BITS = 8;

  typedef enum logic [2:0] {
    EV_START     = 3'd0,
    EV_RSTART    = 3'd1,
    EV_STOP      = 3'd2,
    EV_ADDR7     = 3'd3,
    EV_ADDR10_HI = 3'd4,
    EV_ADDR10_LO = 3'd5,
    EV_DATA      = 3'd6,
    EV_FRAME_ERR = 3'd7
  } evt_kind_e;

  typedef struct packed {
    evt_kind_e              kind;
    logic [BYTE_BITS-1:0]   data;
    logic                   ack;
  } evt_rec_t;
endpackage

// File: rtl/i2c_line_filter.sv
module i2c_line_filter #(
  parameter int unsigned FILT_LEN = 4,
  parameter bit          RST_VAL  = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  output logic line_o
);
  localparam int unsigned CW = $clog2(FILT_LEN + 1);

  logic [1:0]    sync_q;
  logic [CW-1:0] cnt_q;
  logic          line_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= {2{RST_VAL}};
      cnt_q  <= '0;
      line_q <= RST_VAL;
    end else begin
      sync_q <= {sync_q[0], line_i};
      if (sync_q[1] == line_q) begin
        cnt_q <= '0;
      end else if (cnt_q == CW'(FILT_LEN - 1)) begin
        // new level held long enough
        line_q <= sync_q[1];
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign line_o = line_q;
endmodule

// File: rtl/i2c_cond_detect.sv
module i2c_cond_detect (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic start_o,
  output logic stop_o,
  output logic scl_fall_o,
  output logic sda_prev_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign start_o    = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_o     = scl_i & scl_q & ~sda_q & sda_i;
  assign scl_fall_o = scl_q & ~scl_i;
  // level held during the high phase that just ended
  assign sda_prev_o = sda_q;
endmodule

// File: rtl/i2c_byte_framer.sv
module i2c_byte_framer
  import i2c_mon_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     start_i,
  input  logic     stop_i,
  input  logic     scl_fall_i,
  input  logic     sda_bit_i,
  output logic     evt_valid_o,
  output evt_rec_t evt_o
);
  localparam int unsigned CNT_W = $clog2(BYTE_BITS + 2);

  logic                 busy_q, skip_q, first_q, lo_next_q;
  logic [CNT_W-1:0]     bit_cnt_q;
  logic [BYTE_BITS-1:0] shreg_q;
  logic                 pend_v_q;
  evt_kind_e            pend_kind_q;
  logic                 valid_q;
  evt_rec_t             evt_q;

  evt_kind_e cond_kind, byte_kind;
  logic      mid_byte, hi_match;

  always_comb begin
    cond_kind = start_i ? (busy_q ? EV_RSTART : EV_START) : EV_STOP;
    mid_byte  = busy_q && (bit_cnt_q != '0);
    hi_match  = (shreg_q[BYTE_BITS-1 -: 5] == 5'b11110);
    if (first_q)        byte_kind = hi_match ? EV_ADDR10_HI : EV_ADDR7;
    else if (lo_next_q) byte_kind = EV_ADDR10_LO;
    else                byte_kind = EV_DATA;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q      <= 1'b0;
      skip_q      <= 1'b0;
      first_q     <= 1'b0;
      lo_next_q   <= 1'b0;
      bit_cnt_q   <= '0;
      shreg_q     <= '0;
      pend_v_q    <= 1'b0;
      pend_kind_q <= EV_STOP;
      valid_q     <= 1'b0;
      evt_q       <= '{kind: EV_START, data: '0, ack: 1'b0};
    end else begin
      valid_q <= 1'b0;
      if (pend_v_q) begin
        valid_q  <= 1'b1;
        evt_q    <= '{kind: pend_kind_q, data: '0, ack: 1'b0};
        pend_v_q <= 1'b0;
      end
      if (start_i || (stop_i && busy_q)) begin
        valid_q   <= 1'b1;
        bit_cnt_q <= '0;
        lo_next_q <= 1'b0;
        busy_q    <= start_i;
        skip_q    <= start_i;
        first_q   <= start_i;
        if (mid_byte) begin
          // abort partial byte, condition follows next cycle
          evt_q       <= '{kind: EV_FRAME_ERR, data: '0, ack: 1'b0};
          pend_v_q    <= 1'b1;
          pend_kind_q <= cond_kind;
        end else begin
          evt_q <= '{kind: cond_kind, data: '0, ack: 1'b0};
        end
      end else if (scl_fall_i && busy_q && !stop_i) begin
        if (skip_q) begin
          skip_q <= 1'b0;
        end else if (bit_cnt_q == CNT_W'(BYTE_BITS)) begin
          valid_q   <= 1'b1;
          evt_q     <= '{kind: byte_kind, data: shreg_q, ack: ~sda_bit_i};
          bit_cnt_q <= '0;
          first_q   <= 1'b0;
          lo_next_q <= first_q && hi_match && !shreg_q[0];
        end else begin
          shreg_q   <= {shreg_q[BYTE_BITS-2:0], sda_bit_i};
          bit_cnt_q <= bit_cnt_q + 1'b1;
        end
      end
    end
  end

  assign evt_valid_o = valid_q;
  assign evt_o       = evt_q;
endmodule

// File: rtl/i2c_event_monitor.sv
module i2c_event_monitor
  import i2c_mon_pkg::*;
#(
  parameter int unsigned FILT_LEN = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 scl_i,
  input  logic                 sda_i,
  output logic                 evt_valid_o,
  output logic [2:0]           evt_kind_o,
  output logic [BYTE_BITS-1:0] evt_data_o,
  output logic                 evt_ack_o,
  output logic                 evt_rw_o
);
  localparam int unsigned N_LINES = 2;

  logic [N_LINES-1:0] raw_lines, clean_lines;
  logic start, stop, scl_fall, sda_bit;
  logic     evt_valid;
  evt_rec_t evt;

  assign raw_lines = {scl_i, sda_i};

  for (genvar g = 0; g < N_LINES; g++) begin : g_filt
    i2c_line_filter #(.FILT_LEN(FILT_LEN), .RST_VAL(1'b1)) filt_i (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .line_i (raw_lines[g]),
      .line_o (clean_lines[g])
    );
  end

  i2c_cond_detect cond_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (clean_lines[1]),
    .sda_i      (clean_lines[0]),
    .start_o    (start),
    .stop_o     (stop),
    .scl_fall_o (scl_fall),
    .sda_prev_o (sda_bit)
  );

  i2c_byte_framer framer_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start),
    .stop_i      (stop),
    .scl_fall_i  (scl_fall),
    .sda_bit_i   (sda_bit),
    .evt_valid_o (evt_valid),
    .evt_o       (evt)
  );

  assign evt_valid_o = evt_valid;
  assign evt_kind_o  = evt.kind;
  assign evt_data_o  = evt.data;
  assign evt_ack_o   = evt.ack;
  assign evt_rw_o    = evt_valid && (evt.kind inside {EV_ADDR7, EV_ADDR10_HI}) && evt.data[0];
endmodule

// File: rtl/i2c_event_monitor_chk.sv
module i2c_event_monitor_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       evt_valid_o,
  input logic [2:0] evt_kind_o,
  input logic [7:0] evt_data_o
);
  logic seen_busy_q, lo_ok_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_busy_q <= 1'b0;
      lo_ok_q     <= 1'b0;
    end else if (evt_valid_o) begin
      if (evt_kind_o == 3'd0 || evt_kind_o == 3'd1) seen_busy_q <= 1'b1;
      if (evt_kind_o == 3'd2)                       seen_busy_q <= 1'b0;
      lo_ok_q <= (evt_kind_o == 3'd4) && !evt_data_o[0];
    end
  end

  assert_start_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_valid_o && evt_kind_o == 3'd0) |-> !seen_busy_q);

  assert_stop_busy_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_valid_o && evt_kind_o == 3'd2) |-> seen_busy_q);

  assert_rstart_busy_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_valid_o && evt_kind_o == 3'd1) |-> seen_busy_q);

  assert_byte_gap_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_valid_o && evt_kind_o inside {3'd3, 3'd4, 3'd5, 3'd6}) |=> !evt_valid_o);

  assert_lo_after_hi_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_valid_o && evt_kind_o == 3'd5) |-> lo_ok_q);

  assert_err_then_cond_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_valid_o && evt_kind_o == 3'd7) |=> (evt_valid_o && evt_kind_o inside {3'd0, 3'd1, 3'd2}));
endmodule

bind i2c_event_monitor i2c_event_monitor_chk chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .evt_valid_o (evt_valid_o),
  .evt_kind_o  (evt_kind_o),
  .evt_data_o  (evt_data_o)
);

// File: tb/i2c_event_monitor_tb_top.sv
module i2c_event_monitor_tb_top;
  localparam int W = 8;      // system cycles per SCL phase step
  localparam int N_VEC = 6;
  // {b0, b1, b2, ack0, ack1, ack2, kind0, kind1}; b2 is always kind 6
  localparam logic [32:0] VEC [N_VEC] = '{
    {8'hA0, 8'h55, 8'hAA, 3'b111, 3'd3, 3'd6},
    {8'hA1, 8'h3C, 8'hC3, 3'b110, 3'd3, 3'd6},
    {8'hF0, 8'h5A, 8'h01, 3'b111, 3'd4, 3'd5},
    {8'hF1, 8'h00, 8'hFF, 3'b100, 3'd4, 3'd6},
    {8'h00, 8'hFF, 8'h80, 3'b011, 3'd3, 3'd6},
    {8'hF8, 8'h81, 8'h7E, 3'b101, 3'd3, 3'd6}
  };

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic scl_r = 1'b1, sda_r = 1'b1;
  logic       evt_valid_o, evt_ack_o, evt_rw_o;
  logic [2:0] evt_kind_o;
  logic [7:0] evt_data_o;

  int n_checks = 0, n_fail = 0;
  bit done = 1'b0;
  logic [12:0] evq[$];  // {kind, ack, rw, data}

  always #4 clk_i = ~clk_i;

  i2c_event_monitor dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .scl_i(scl_r), .sda_i(sda_r),
    .evt_valid_o(evt_valid_o), .evt_kind_o(evt_kind_o), .evt_data_o(evt_data_o),
    .evt_ack_o(evt_ack_o), .evt_rw_o(evt_rw_o)
  );

  always @(negedge clk_i)
    if (rst_ni && evt_valid_o) evq.push_back({evt_kind_o, evt_ack_o, evt_rw_o, evt_data_o});

  task automatic wh(); repeat (W) @(negedge clk_i); endtask
  task automatic bus_start(); sda_r = 1; scl_r = 1; wh(); sda_r = 0; wh(); scl_r = 0; endtask
  task automatic bus_rstart(); wh(); sda_r = 1; wh(); scl_r = 1; wh(); sda_r = 0; wh(); scl_r = 0; endtask
  task automatic bus_stop(); wh(); sda_r = 0; wh(); scl_r = 1; wh(); sda_r = 1; wh(); endtask
  task automatic send_bit(input logic b); wh(); sda_r = b; wh(); scl_r = 1; wh(); scl_r = 0; endtask
  task automatic send_byte(input logic [7:0] v, input logic ack);
    for (int i = 7; i >= 0; i--) send_bit(v[i]);
    send_bit(~ack);
  endtask

  task automatic check(input string req, input logic [12:0] act, input logic [12:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual kind=%0d ack=%0b rw=%0b data=%h, expected kind=%0d ack=%0b rw=%0b data=%h",
               req, act[12:10], act[9], act[8], act[7:0], exp[12:10], exp[9], exp[8], exp[7:0]);
    end
  endtask

  task automatic expect_evt(input string req, input logic [2:0] k, input logic a,
                            input logic rw, input logic [7:0] d);
    logic [12:0] act;
    act = (evq.size() > 0) ? evq.pop_front() : 13'h1FFF;
    check(req, act, {k, a, rw, d});
  endtask

  task automatic expect_empty(input string req);
    n_checks++;
    if (evq.size() != 0) begin
      n_fail++;
      $display("FAIL %s: actual %0d extra records, expected 0", req, evq.size());
      evq.delete();
    end
  endtask

  task automatic settle(); repeat (30) @(negedge clk_i); endtask

  initial begin
    repeat (5) @(negedge clk_i);
    n_checks++;
    if (evt_valid_o !== 1'b0) begin
      n_fail++; $display("FAIL R1: actual valid=%b, expected 0 in reset", evt_valid_o);
    end
    rst_ni = 1'b1;
    repeat (20) @(negedge clk_i);
    expect_empty("R1 idle after reset");

    // table walk: start, address, two bytes, stop
    for (int v = 0; v < N_VEC; v++) begin
      logic [32:0] e;
      e = VEC[v];
      bus_start();
      send_byte(e[32:25], e[8]);
      send_byte(e[24:17], e[7]);
      send_byte(e[16:9], e[6]);
      bus_stop();
      settle();
      expect_evt("R2 start", 3'd0, 0, 0, 8'h00);
      expect_evt("R6 R7 first byte", e[5:3], e[8], e[25], e[32:25]);
      expect_evt("R7 R8 second byte", e[2:0], e[7], 0, e[24:17]);
      expect_evt("R5 R8 data byte", 3'd6, e[6], 0, e[16:9]);
      expect_evt("R3 stop", 3'd2, 0, 0, 8'h00);
      expect_empty("R8 table tail");
    end

    // R3: stop condition while idle gives nothing
    scl_r = 0; wh(); sda_r = 0; wh(); scl_r = 1; wh(); sda_r = 1; settle();
    expect_empty("R3 stop while idle");

    // R4: repeated start, second address read
    bus_start(); send_byte(8'hA0, 1); send_byte(8'h11, 1);
    bus_rstart(); send_byte(8'hA1, 1); send_byte(8'h22, 0); send_byte(8'h33, 1);
    bus_stop(); settle();
    expect_evt("R2", 3'd0, 0, 0, 8'h00);
    expect_evt("R6", 3'd3, 1, 0, 8'hA0);
    expect_evt("R8", 3'd6, 1, 0, 8'h11);
    expect_evt("R4 rstart", 3'd1, 0, 0, 8'h00);
    expect_evt("R6 read", 3'd3, 1, 1, 8'hA1);
    expect_evt("R5 nack", 3'd6, 0, 0, 8'h22);
    expect_evt("R8 third", 3'd6, 1, 0, 8'h33);
    expect_evt("R3", 3'd2, 0, 0, 8'h00);
    expect_empty("R4 tail");

    // R9 + R4: repeated start after three bits
    bus_start(); send_byte(8'hA2, 1);
    send_bit(1); send_bit(0); send_bit(1);
    bus_rstart(); send_byte(8'hA4, 1); bus_stop(); settle();
    expect_evt("R2", 3'd0, 0, 0, 8'h00);
    expect_evt("R6", 3'd3, 1, 0, 8'hA2);
    expect_evt("R9 error", 3'd7, 0, 0, 8'h00);
    expect_evt("R9 R4 rstart", 3'd1, 0, 0, 8'h00);
    expect_evt("R4 counter reset", 3'd3, 1, 0, 8'hA4);
    expect_evt("R3", 3'd2, 0, 0, 8'h00);
    expect_empty("R9 tail");

    // R9: stop after five bits
    bus_start(); send_bit(1); send_bit(1); send_bit(0); send_bit(1); send_bit(1);
    bus_stop(); settle();
    expect_evt("R2", 3'd0, 0, 0, 8'h00);
    expect_evt("R9 error", 3'd7, 0, 0, 8'h00);
    expect_evt("R9 stop", 3'd2, 0, 0, 8'h00);
    expect_empty("R9 stop tail");

    // R7: upper ten-bit byte then repeated start clears lower-byte expectation
    bus_start(); send_byte(8'hF6, 1); bus_rstart(); send_byte(8'hF7, 1);
    send_byte(8'h44, 1); bus_stop(); settle();
    expect_evt("R2", 3'd0, 0, 0, 8'h00);
    expect_evt("R7 hi", 3'd4, 1, 0, 8'hF6);
    expect_evt("R4", 3'd1, 0, 0, 8'h00);
    expect_evt("R7 hi read", 3'd4, 1, 1, 8'hF7);
    expect_evt("R7 R8 data", 3'd6, 1, 0, 8'h44);
    expect_evt("R3", 3'd2, 0, 0, 8'h00);
    expect_empty("R7 tail");

    // R10: short SDA pulse with SCL high ignored
    sda_r = 0; repeat (2) @(negedge clk_i); sda_r = 1; settle();
    expect_empty("R10 glitch");
    // R10: long pulse seen as start then stop
    sda_r = 0; repeat (7) @(negedge clk_i); sda_r = 1; settle();
    expect_evt("R10 long start", 3'd0, 0, 0, 8'h00);
    expect_evt("R10 long stop", 3'd2, 0, 0, 8'h00);
    expect_empty("R10 tail");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual run unfinished, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule